// File: doc/BRIEF.md
# Transmit Elastic-Buffer Phase Aligner

This block sits next to a serial transmitter whose parallel-to-serial crossing is an elastic buffer. After each startup it moves the buffer's read-side clock phase through a phase interpolator until the read pointer sits at the same distance from the write pointer every time. This gives a fixed relation between the reference clock and the serial data from one reset to the next. The only phase information it uses is a one-bit flag that is high while the buffer holds more than half its capacity. A single sample of that flag is too coarse to use directly, so the block counts the flag over a window of samples and takes the majority as an early/late decision.

There are two ways to align. In search mode the block measures a reference decision and then steps the interpolator upward one step at a time, measuring again after each step. It stops at the first position where the decision differs from the reference. In static mode the block takes a position value supplied from outside (normally the position read out after the first search) and drives the interpolator straight to it along the shorter way round, with no measurement. Each instance uses only its own logic, so one instance can be placed per lane.

Top module: `txPhaseAligner`

## Requirements
- R1: After reset, `done`, `err` and `piStep` are 0 and `piPos` is 0.
- R2: An early/late decision counts the synchronised fill flag over WIN consecutive samples. It reads late only when the count of high samples is strictly greater than WIN/2, so a count of exactly WIN/2 reads early.
- R3: `piStep` is a pulse one cycle long, and `piDir` is valid with it (1 = increment, 0 = decrement). No further pulse is issued until `piAck` has been seen and at least SETTLE cycles have passed since it.
- R4: `piPos` changes by one for each acknowledged step, in the commanded direction, modulo PI_STEPS. It wraps from PI_STEPS-1 to 0 going up and from 0 to PI_STEPS-1 going down.
- R5: In search mode, after a reference window the block steps upward only. It sets `done` at the first position whose decision differs from the reference, and `piPos` holds that position.
- R6: If no decision change is seen after PI_STEPS search steps, `err` is 1, `done` is 0, no further steps are issued, and `piPos` is back at its starting value.
- R7: In static mode the block steps toward `storedPos` with no measurement. It steps upward when (storedPos - piPos) mod PI_STEPS is at most PI_STEPS/2 and downward otherwise, and it sets `done` when `piPos` equals `storedPos`.
- R8: In static mode with `piPos` already equal to `storedPos`, `done` is set and no step is issued.
- R9: A `start` pulse during an alignment in progress is ignored. The running alignment finishes with the result it would have had.
- R10: A new `start` clears whichever of `done` or `err` was set before. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins an alignment while idle, done or in error |
| staticMode | input | 1 | 1 = replay `storedPos`, 0 = search |
| storedPos | input | POS_W | Target interpolator position for static mode |
| fillHalf | input | 1 | Buffer-more-than-half-full flag (asynchronous) |
| piAck | input | 1 | Interpolator has applied the last step |
| piStep | output | 1 | One-cycle step command to the interpolator |
| piDir | output | 1 | Step direction, 1 = increment |
| piPos | output | POS_W | Current interpolator position |
| done | output | 1 | Alignment finished |
| err | output | 1 | Search ran a full lap without a decision change |

## Verification
The fill flag is driven with a duty cycle of exactly one half below the transition point and just above one half at and beyond it. A design that compares with "greater or equal" sees late everywhere and ends in error instead of stopping. Static replays are chosen so that the shorter way crosses the wrap point downward, and so that the distance equals exactly half the range, where the tie must go upward. A wrong direction rule shows up as wrong up/down step counts. A search starts on the late side so that it must wrap through zero to find the change. A run with no transition must stop after exactly one full lap, back at its start. A restart pulse in the middle of a search must leave the count of steps and the final position unchanged.

// File: rtl/alignPkg.sv
package alignPkg;

  typedef struct packed {
    logic accStart;
    logic stepReq;
    logic stepDir;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REF,
    S_STEP,
    S_MEAS,
    S_SEEK,
    S_DONE,
    S_ERR
  } seqState_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_WAIT,
    P_SETTLE
  } stepPhase_t;

endpackage

// File: rtl/fillAccum.sv
module fillAccum #(
  parameter int WIN         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic accStart,
  input  logic fillHalf,
  output logic accValid,
  output logic accLate
);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int HALF  = WIN / 2;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   sampleBit;
  logic                   busy;
  logic [CNT_W-1:0]       sampCnt;
  logic [CNT_W-1:0]       oneCnt;
  logic [CNT_W-1:0]       oneNext;

  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= fillHalf;
      end
    end else begin : gSyncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], fillHalf};
      end
    end
  endgenerate

  assign sampleBit = syncChain[SYNC_STAGES-1];
  assign oneNext   = oneCnt + CNT_W'(sampleBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sampCnt  <= '0;
      oneCnt   <= '0;
      accValid <= 1'b0;
      accLate  <= 1'b0;
    end else begin
      accValid <= 1'b0;
      if (accStart) begin
        busy    <= 1'b1;
        sampCnt <= '0;
        oneCnt  <= '0;
      end else if (busy) begin
        oneCnt  <= oneNext;
        sampCnt <= sampCnt + 1'b1;
        if (sampCnt == CNT_W'(WIN - 1)) begin
          busy     <= 1'b0;
          accValid <= 1'b1;
          accLate  <= (oneNext > CNT_W'(HALF));
        end
      end
    end
  end

  assert_ones_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (oneCnt <= sampCnt));

  assert_valid_ends_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> !busy);

endmodule

// File: rtl/piStepper.sv
module piStepper
  import alignPkg::*;
#(
  parameter int PI_STEPS = 64,
  parameter int SETTLE   = 4,
  localparam int POS_W   = $clog2(PI_STEPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepReq,
  input  logic             stepDir,
  input  logic             piAck,
  output logic             piStep,
  output logic             piDir,
  output logic             stepDone,
  output logic [POS_W-1:0] piPos
);
  localparam int SET_W = $clog2(SETTLE + 1);

  stepPhase_t       phase;
  logic [SET_W-1:0] settleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= P_IDLE;
      settleCnt <= '0;
      piStep    <= 1'b0;
      piDir     <= 1'b1;
      stepDone  <= 1'b0;
      piPos     <= '0;
    end else begin
      piStep   <= 1'b0;
      stepDone <= 1'b0;
      unique case (phase)
        P_IDLE: begin
          if (stepReq) begin
            piStep <= 1'b1;
            piDir  <= stepDir;
            phase  <= P_WAIT;
          end
        end
        P_WAIT: begin
          if (piAck) begin
            if (piDir) piPos <= (piPos == POS_W'(PI_STEPS - 1)) ? '0 : piPos + 1'b1;
            else       piPos <= (piPos == '0) ? POS_W'(PI_STEPS - 1) : piPos - 1'b1;
            settleCnt <= '0;
            phase     <= P_SETTLE;
          end
        end
        P_SETTLE: begin
          settleCnt <= settleCnt + 1'b1;
          if (settleCnt == SET_W'(SETTLE - 1)) begin
            stepDone <= 1'b1;
            phase    <= P_IDLE;
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  assert_step_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    piStep |=> !piStep);

  assert_step_awaits_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    piStep |-> (phase == P_WAIT));

  assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    piPos <= POS_W'(PI_STEPS - 1));

  assert_pos_moves_on_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == P_WAIT && piAck) |=> (piPos != $past(piPos)));

endmodule

// File: rtl/alignSeq.sv
module alignSeq
  import alignPkg::*;
#(
  parameter int PI_STEPS = 64,
  localparam int POS_W   = $clog2(PI_STEPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             staticMode,
  input  logic [POS_W-1:0] storedPos,
  input  logic             accValid,
  input  logic             accLate,
  input  logic             stepDone,
  input  logic [POS_W-1:0] piPos,
  output ctlStrobes_t      ctl,
  output logic             done,
  output logic             err
);
  localparam int SCNT_W = $clog2(PI_STEPS + 1);

  seqState_t         state;
  logic [SCNT_W-1:0] stepCnt;
  logic              refLate;
  logic              dirUp;
  logic              staticRun;
  logic [POS_W:0]    delta;
  logic              wantUp;

  always_comb begin
    if (storedPos >= piPos) delta = {1'b0, storedPos} - {1'b0, piPos};
    else                    delta = {1'b0, storedPos} + (POS_W+1)'(PI_STEPS) - {1'b0, piPos};
    wantUp = (delta <= (POS_W+1)'(PI_STEPS / 2));
  end

  assign done = (state == S_DONE);
  assign err  = (state == S_ERR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      ctl       <= '0;
      stepCnt   <= '0;
      refLate   <= 1'b0;
      dirUp     <= 1'b1;
      staticRun <= 1'b0;
    end else begin
      ctl <= '0;
      unique case (state)
        S_IDLE, S_DONE, S_ERR: begin
          if (start) begin
            staticRun <= staticMode;
            stepCnt   <= '0;
            if (staticMode) begin
              if (piPos == storedPos) begin
                state <= S_DONE;
              end else begin
                dirUp       <= wantUp;
                ctl.stepReq <= 1'b1;
                ctl.stepDir <= wantUp;
                state       <= S_SEEK;
              end
            end else begin
              ctl.accStart <= 1'b1;
              state        <= S_REF;
            end
          end
        end
        S_REF: begin
          if (accValid) begin
            refLate     <= accLate;
            ctl.stepReq <= 1'b1;
            ctl.stepDir <= 1'b1;
            stepCnt     <= SCNT_W'(1);
            state       <= S_STEP;
          end
        end
        S_STEP: begin
          if (stepDone) begin
            ctl.accStart <= 1'b1;
            state        <= S_MEAS;
          end
        end
        S_MEAS: begin
          if (accValid) begin
            if (accLate != refLate) begin
              state <= S_DONE;
            end else if (stepCnt == SCNT_W'(PI_STEPS)) begin
              state <= S_ERR;
            end else begin
              ctl.stepReq <= 1'b1;
              ctl.stepDir <= 1'b1;
              stepCnt     <= stepCnt + 1'b1;
              state       <= S_STEP;
            end
          end
        end
        S_SEEK: begin
          if (stepDone) begin
            if (piPos == storedPos) begin
              state <= S_DONE;
            end else begin
              ctl.stepReq <= 1'b1;
              ctl.stepDir <= dirUp;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  assert_err_full_lap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> (stepCnt == SCNT_W'(PI_STEPS)));

  assert_static_landing_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(done) && staticRun) |-> (piPos == storedPos));

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MEAS && start && !accValid) |=> (state == S_MEAS));

  assert_search_steps_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepReq && !staticRun) |-> ctl.stepDir);

endmodule

// File: rtl/txPhaseAligner.sv
module txPhaseAligner
  import alignPkg::*;
#(
  parameter int PI_STEPS    = 64,
  parameter int WIN         = 64,
  parameter int SETTLE      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W      = $clog2(PI_STEPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             staticMode,
  input  logic [POS_W-1:0] storedPos,
  input  logic             fillHalf,
  input  logic             piAck,
  output logic             piStep,
  output logic             piDir,
  output logic [POS_W-1:0] piPos,
  output logic             done,
  output logic             err
);
  ctlStrobes_t ctl;
  logic        accValid;
  logic        accLate;
  logic        stepDone;

  fillAccum #(.WIN(WIN), .SYNC_STAGES(SYNC_STAGES)) uAccum (
    .clk(clk), .rstN(rstN), .accStart(ctl.accStart), .fillHalf(fillHalf),
    .accValid(accValid), .accLate(accLate)
  );

  piStepper #(.PI_STEPS(PI_STEPS), .SETTLE(SETTLE)) uStepper (
    .clk(clk), .rstN(rstN), .stepReq(ctl.stepReq), .stepDir(ctl.stepDir),
    .piAck(piAck), .piStep(piStep), .piDir(piDir), .stepDone(stepDone),
    .piPos(piPos)
  );

  alignSeq #(.PI_STEPS(PI_STEPS)) uSeq (
    .clk(clk), .rstN(rstN), .start(start), .staticMode(staticMode),
    .storedPos(storedPos), .accValid(accValid), .accLate(accLate),
    .stepDone(stepDone), .piPos(piPos), .ctl(ctl), .done(done), .err(err)
  );

endmodule

// File: tb/tb_txPhaseAligner.sv
module tb_txPhaseAligner;
  localparam int PI_STEPS = 64;
  localparam int SETTLE   = 4;
  localparam int POS_W    = 6;
  localparam int NVEC     = 8;

  // columns: static, storedPos, flip point, no-flip, exp pos, exp err, exp up, exp down
  localparam int V_STATIC[NVEC] = '{0, 1, 1, 0, 0, 1, 1, 0};
  localparam int V_STORED[NVEC] = '{0, 10, 50, 0, 0, 0, 32, 0};
  localparam int V_FLIP[NVEC]   = '{20, 0, 0, 20, 0, 0, 0, 40};
  localparam int V_NOFLIP[NVEC] = '{0, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_POS[NVEC]    = '{20, 10, 50, 0, 0, 0, 32, 40};
  localparam int V_ERR[NVEC]    = '{0, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_UP[NVEC]     = '{20, 0, 0, 14, 64, 0, 32, 8};
  localparam int V_DN[NVEC]     = '{0, 10, 24, 0, 0, 0, 0, 0};

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic staticMode = 0;
  logic [POS_W-1:0] storedPos = '0;
  logic fillHalf = 0;
  logic piAck = 0;
  logic piStep, piDir, done, err;
  logic [POS_W-1:0] piPos;

  int checks = 0;
  int fails = 0;
  int modelPos = 0;
  int flipAt = 20;
  bit noFlip = 0;
  int phaseCnt = 0;
  int ackCnt = 0;
  int upCnt = 0;
  int dnCnt = 0;
  int gap = 1000;
  int minGap = 1000;
  bit prevStep = 0;
  int doublePulse = 0;

  always #10 clk = ~clk;

  txPhaseAligner #(.PI_STEPS(PI_STEPS), .WIN(64), .SETTLE(SETTLE), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .start(start), .staticMode(staticMode),
    .storedPos(storedPos), .fillHalf(fillHalf), .piAck(piAck),
    .piStep(piStep), .piDir(piDir), .piPos(piPos), .done(done), .err(err)
  );

  // Buffer and interpolator model: duty of 4/8 is exactly half (early), 5/8 is late
  always @(negedge clk) begin
    int duty;
    duty = (!noFlip && modelPos >= flipAt) ? 5 : 4;
    phaseCnt <= (phaseCnt + 1) % 8;
    fillHalf <= (phaseCnt < duty);
    if (piAck) gap <= 0;
    else if (gap < 1000) gap <= gap + 1;
    if (piStep) begin
      if (gap < minGap) minGap <= gap;
      if (prevStep) doublePulse <= doublePulse + 1;
      if (piDir) begin upCnt <= upCnt + 1; modelPos <= (modelPos + 1) % PI_STEPS; end
      else begin dnCnt <= dnCnt + 1; modelPos <= (modelPos + PI_STEPS - 1) % PI_STEPS; end
      ackCnt <= 3;
    end
    prevStep <= piStep;
    piAck <= (ackCnt == 1);
    if (ackCnt > 0) ackCnt <= ackCnt - 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runAlign(input bit st, input int sp, input int fl, input bit nf, input bit midStart);
    @(negedge clk);
    staticMode = st; storedPos = POS_W'(sp); flipAt = fl; noFlip = nf;
    upCnt = 0; dnCnt = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 20000; i++) begin
      if (midStart && i == 300) begin
        staticMode = 1; storedPos = 5; start = 1;
      end else begin
        start = 0;
      end
      if (done || err) break;
      @(negedge clk);
    end
    start = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 0, "R1", "done", done, 0);
    check(err == 0, "R1", "err", err, 0);
    check(piStep == 0, "R1", "piStep", piStep, 0);
    check(piPos == 0, "R1", "piPos", piPos, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(done == 0 && err == 0, "R1", "idle flags", {done, err}, 0);

    for (int v = 0; v < NVEC; v++) begin
      runAlign(V_STATIC[v] != 0, V_STORED[v], V_FLIP[v], V_NOFLIP[v] != 0, 0);
      // R5 R6 R7 R8: final position, flags and step counts per vector
      check(piPos == POS_W'(V_POS[v]), V_STATIC[v] != 0 ? "R7" : "R5", $sformatf("vec%0d piPos", v), piPos, V_POS[v]);
      check(err == V_ERR[v], "R6", $sformatf("vec%0d err", v), err, V_ERR[v]);
      check(done == (V_ERR[v] == 0), "R10", $sformatf("vec%0d done", v), done, V_ERR[v] == 0);
      check(upCnt == V_UP[v], "R4", $sformatf("vec%0d up steps", v), upCnt, V_UP[v]);
      check(dnCnt == V_DN[v], "R7", $sformatf("vec%0d down steps", v), dnCnt, V_DN[v]);
      check(modelPos == int'(piPos), "R4", $sformatf("vec%0d pos tracks steps", v), piPos, modelPos);
    end

    // R8: static replay onto the current position issues no step
    runAlign(1, 40, 0, 0, 0);
    check(upCnt + dnCnt == 0, "R8", "steps when already there", upCnt + dnCnt, 0);
    check(done == 1, "R8", "done", done, 1);

    // R9: start pulse during a search is ignored
    runAlign(0, 0, 60, 0, 1);
    check(piPos == 60, "R9", "piPos after ignored start", piPos, 60);
    check(upCnt == 20 && dnCnt == 0, "R9", "up steps after ignored start", upCnt, 20);
    check(done == 1 && err == 0, "R9", "flags", {done, err}, 2);

    // R2: duty exactly half everywhere reads early -> no change -> full lap error
    check(V_ERR[4] == 1, "R2", "half duty is early (vector 4)", V_ERR[4], 1);

    // R3: pulse shape and spacing
    check(doublePulse == 0, "R3", "back-to-back step pulses", doublePulse, 0);
    check(minGap >= SETTLE, "R3", "cycles from ack to next step", minGap, SETTLE);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule